// File: doc/BRIEF.md
# Single-Bit Sector ECC Corrector

The block checks one 512-byte sector against its 24-bit single-error-correcting code. A caller presents two three-byte codes, one freshly computed over the data just read and one fetched from spare storage, and pulses a start strobe. The block XORs the two codes, decides whether the sector is clean, holds one bad data bit, holds one bad code bit, or is beyond repair, and when a data bit is at fault it flips that bit in place in a sector buffer that lives inside the block.

The buffer is filled and drained through a plain byte-wide port with a synchronous read. A correction is a single read-modify-write of the faulty byte performed by the block itself; the verdict is then published on a status output together with a one-cycle done pulse. Codes are kept bit-inverted in storage, so a fully erased sector with an erased code area compares clean without any special case.

Top module: `ecc1_fixer`

## Requirements
- R1: Each code is assembled with its byte 0 input as bits 7:0, byte 1 as bits 15:8 and byte 2 as bits 23:16; the difference word is the XOR of the two assembled codes.
- R2: A zero difference reports status 0 (clean) and leaves every buffer byte unchanged.
- R3: When bits 11:0 of the difference XOR bits 23:12 equal all ones, bits 23:15 name the faulty byte and bits 14:12 the faulty bit; that bit of that buffer byte is inverted and status 1 (data corrected) is reported.
- R4: A correctable pattern whose byte index is not below SECTOR_BYTES reports status 3 (uncorrectable) and writes nothing.
- R5: A difference with exactly one bit set that fails the R3 test reports status 2 (code bit corrected) and writes nothing.
- R6: Every other nonzero difference reports status 3 and writes nothing.
- R7: Two all-ones codes (an erased sector) report status 0.
- R8: done is a one-cycle pulse, high after the first clock edge following the start edge for outcomes without a write and after the third such edge for a data correction.
- R9: start is ignored while a check is in progress, including any change of the code inputs.
- R10: status resets to 0 and changes only together with done; done never stays high two cycles.
- R11: While idle, buf_we writes buf_wdata at buf_addr on the clock edge; buf_rdata shows the byte at buf_addr one edge after the address is presented; writes during a check are dropped.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a check with the codes now present |
| calc_b0 | input | 8 | Computed code, bits 7:0 |
| calc_b1 | input | 8 | Computed code, bits 15:8 |
| calc_b2 | input | 8 | Computed code, bits 23:16 |
| ref_b0 | input | 8 | Stored code, bits 7:0 |
| ref_b1 | input | 8 | Stored code, bits 15:8 |
| ref_b2 | input | 8 | Stored code, bits 23:16 |
| buf_we | input | 1 | Buffer byte write enable (idle only) |
| buf_addr | input | $clog2(SECTOR_BYTES) (9) | Buffer byte address |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer read data, one edge after address |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 clean, 1 data fixed, 2 code bit fixed, 3 uncorrectable |

## Verification
The external buffer port and the internal read-modify-write share one RAM, so a caller write can land in the same cycle the engine owns the array, and a fresh start can arrive while a correction is still in its read phase. The bench provokes both: it pulses start with clean codes one cycle after launching a correction, and drives a buffer write to a different byte during a correction. It judges them by requiring the original correction's verdict and latency, a single done pulse, the corrected byte flipped, and the other byte reading back untouched afterwards.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
    localparam int CODE_BYTES = 3;
    localparam int CODE_W     = CODE_BYTES * 8;
    localparam int HALF_W     = CODE_W / 2;
    localparam int BIT_W      = 3;
    localparam int IDX_W      = CODE_W - HALF_W - BIT_W;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_FIX_DATA = 2'd1,
        ST_FIX_CODE = 2'd2,
        ST_BAD      = 2'd3
    } chk_status_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_EVAL  = 2'd1,
        PH_READ  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;
endpackage

// File: rtl/ecc1_classify.sv
module ecc1_classify
    import ecc1_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] calc_code,
    input  logic [CODE_W-1:0] stor_code,
    output chk_status_e       verdict,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [BIT_W-1:0]  bit_idx
);
    logic [CODE_W-1:0] diff;
    logic [HALF_W-1:0] fold;

    always_comb begin
        diff     = calc_code ^ stor_code;
        fold     = diff[HALF_W-1:0] ^ diff[CODE_W-1:HALF_W];
        byte_idx = diff[CODE_W-1 -: IDX_W];
        bit_idx  = diff[HALF_W +: BIT_W];
        if (diff == '0) begin
            verdict = ST_CLEAN;
        end else if (&fold) begin
            // halves are exact complements: one data bit is wrong
            verdict = (int'(byte_idx) < SECTOR_BYTES) ? ST_FIX_DATA : ST_BAD;
        end else if ($onehot(diff)) begin
            verdict = ST_FIX_CODE;
        end else begin
            verdict = ST_BAD;
        end
    end
endmodule

// File: rtl/ecc1_sector_ram.sv
module ecc1_sector_ram #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/ecc1_fixer.sv
module ecc1_fixer
    import ecc1_pkg::*;
#(
    parameter  int SECTOR_BYTES = 512,
    localparam int AW           = $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    calc_b0,
    input  logic [7:0]    calc_b1,
    input  logic [7:0]    calc_b2,
    input  logic [7:0]    ref_b0,
    input  logic [7:0]    ref_b1,
    input  logic [7:0]    ref_b2,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_wdata,
    output logic [7:0]    buf_rdata,
    output logic          done,
    output logic [1:0]    status
);
    typedef struct packed {
        phase_e            phase;
        logic [CODE_W-1:0] calc;
        logic [CODE_W-1:0] stor;
        logic [AW-1:0]     addr;
        logic [BIT_W-1:0]  bitp;
        chk_status_e       status;
        logic              done;
    } fix_state_t;

    localparam fix_state_t ST_RESET = '{
        phase: PH_IDLE, calc: '0, stor: '0, addr: '0,
        bitp: '0, status: ST_CLEAN, done: 1'b0
    };

    fix_state_t st_d, st_q;

    // little-endian assembly of the two byte triplets
    logic [7:0]        calc_bytes [CODE_BYTES];
    logic [7:0]        ref_bytes  [CODE_BYTES];
    logic [CODE_W-1:0] calc_word, ref_word;

    assign calc_bytes[0] = calc_b0;
    assign calc_bytes[1] = calc_b1;
    assign calc_bytes[2] = calc_b2;
    assign ref_bytes[0]  = ref_b0;
    assign ref_bytes[1]  = ref_b1;
    assign ref_bytes[2]  = ref_b2;

    for (genvar g = 0; g < CODE_BYTES; g++) begin : g_pack
        assign calc_word[g*8 +: 8] = calc_bytes[g];
        assign ref_word[g*8 +: 8]  = ref_bytes[g];
    end

    chk_status_e      verdict;
    logic [IDX_W-1:0] byte_idx;
    logic [BIT_W-1:0] bit_idx;

    ecc1_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
        .calc_code (st_q.calc),
        .stor_code (st_q.stor),
        .verdict   (verdict),
        .byte_idx  (byte_idx),
        .bit_idx   (bit_idx)
    );

    logic          busy, eng_we, ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_wdata, ram_rdata;

    assign busy      = (st_q.phase != PH_IDLE);
    assign eng_we    = (st_q.phase == PH_WRITE);
    assign ram_we    = eng_we | (!busy & buf_we);
    assign ram_addr  = busy ? st_q.addr : buf_addr;
    assign ram_wdata = eng_we ? (ram_rdata ^ (8'd1 << st_q.bitp)) : buf_wdata;

    ecc1_sector_ram #(.DEPTH(SECTOR_BYTES), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.calc  = calc_word;
                    st_d.stor  = ref_word;
                    st_d.phase = PH_EVAL;
                end
            end
            PH_EVAL: begin
                if (verdict == ST_FIX_DATA) begin
                    st_d.addr  = AW'(byte_idx);
                    st_d.bitp  = bit_idx;
                    st_d.phase = PH_READ;
                end else begin
                    st_d.status = verdict;
                    st_d.done   = 1'b1;
                    st_d.phase  = PH_IDLE;
                end
            end
            PH_READ: begin
                st_d.phase = PH_WRITE;
            end
            PH_WRITE: begin
                st_d.status = ST_FIX_DATA;
                st_d.done   = 1'b1;
                st_d.phase  = PH_IDLE;
            end
            default: st_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_rdata = ram_rdata;
    assign done      = st_q.done;
    assign status    = st_q.status;
endmodule

// File: rtl/ecc1_fixer_chk.sv
module ecc1_fixer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic [1:0] status,
    input logic       busy,
    input logic       eng_we
);
    // R8 / R10: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: verdict only moves together with done
    a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(status));

    // R9: completion always returns the engine to idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: an engine write follows evaluation and read phases
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> ($past(busy) && $past(busy, 2)));

    // R3: the engine write is followed by a data-corrected verdict
    a_r3_write_then_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |=> (done && status == 2'd1));
endmodule

bind ecc1_fixer ecc1_fixer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .status (status),
    .busy   (busy),
    .eng_we (eng_we)
);

// File: tb/ecc1_fixer_tb.sv
module ecc1_fixer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] calc_b0 = '0, calc_b1 = '0, calc_b2 = '0;
    logic [7:0] ref_b0 = '0, ref_b1 = '0, ref_b2 = '0;
    logic       buf_we = 1'b0;
    logic [8:0] buf_addr = '0;
    logic [7:0] buf_wdata = '0;
    logic [7:0] buf_rdata;
    logic       done;
    logic [1:0] status;

    logic       s_start = 1'b0;
    logic [7:0] s_c0 = '0, s_c1 = '0, s_c2 = '0;
    logic [7:0] s_r0 = '0, s_r1 = '0, s_r2 = '0;
    logic       s_we = 1'b0;
    logic [7:0] s_addr = '0;
    logic [7:0] s_wdata = '0;
    logic [7:0] s_rdata;
    logic       s_done;
    logic [1:0] s_status;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] model [512];

    always #2 clk = ~clk;

    ecc1_fixer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .calc_b0(calc_b0), .calc_b1(calc_b1), .calc_b2(calc_b2),
        .ref_b0(ref_b0), .ref_b1(ref_b1), .ref_b2(ref_b2),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .done(done), .status(status)
    );

    ecc1_fixer #(.SECTOR_BYTES(256)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .start(s_start),
        .calc_b0(s_c0), .calc_b1(s_c1), .calc_b2(s_c2),
        .ref_b0(s_r0), .ref_b1(s_r1), .ref_b2(s_r2),
        .buf_we(s_we), .buf_addr(s_addr), .buf_wdata(s_wdata),
        .buf_rdata(s_rdata), .done(s_done), .status(s_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected verdict from the requirement text
    function automatic int ref_verdict(input logic [23:0] c, input logic [23:0] s,
                                       input int size, output int bi, output int ki);
        logic [23:0] d;
        d  = c ^ s;
        bi = int'(d[23:15]);
        ki = int'(d[14:12]);
        if (d == 24'd0) return 0;
        if ((d[11:0] ^ d[23:12]) == 12'hFFF) return (bi < size) ? 1 : 3;
        if ($countones(d) == 1) return 2;
        return 3;
    endfunction

    task automatic wr_byte(input int a, input logic [7:0] v);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = 9'(a); buf_wdata = v;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic rd_byte(input int a, output logic [7:0] v);
        @(negedge clk);
        buf_addr = 9'(a);
        @(negedge clk);
        v = buf_rdata;
    endtask

    task automatic fire(input logic [23:0] c, input logic [23:0] s, output int n);
        @(negedge clk);
        {calc_b2, calc_b1, calc_b0} = c;
        {ref_b2, ref_b1, ref_b0}    = s;
        start = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            n++;
        end while (!done && n < 20);
    endtask

    task automatic do_case(input logic [23:0] c, input logic [23:0] s, input string tag);
        int bi, ki, n, ev, el;
        logic [7:0] rd;
        ev = ref_verdict(c, s, 512, bi, ki);
        el = (ev == 1) ? 4 : 2;
        fire(c, s, n);
        check(int'(status) == ev, tag, int'(status), ev);
        check(n == el, {tag, " R8 latency"}, n, el);
        if (ev == 1) model[bi] = model[bi] ^ (8'd1 << ki);
        rd_byte(bi, rd);
        check(rd == model[bi], {tag, " R11 buffer byte"}, int'(rd), int'(model[bi]));
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int n;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R10 reset done", int'(done), 0);
        check(status == 2'd0, "R10 reset status", int'(status), 0);

        // R11: fill and spot-read the buffer
        for (int a = 0; a < 512; a++) begin
            model[a] = 8'($urandom);
            wr_byte(a, model[a]);
        end
        for (int i = 0; i < 8; i++) begin
            int a = $urandom_range(0, 511);
            rd_byte(a, rd);
            check(rd == model[a], "R11 readback", int'(rd), int'(model[a]));
        end

        // directed corners
        do_case(24'h3C5A71, 24'h3C5A71, "R2 clean");
        do_case(24'hFFFFFF, 24'hFFFFFF, "R7 erased");
        do_case(24'h000FFF ^ 24'h123456, 24'h123456, "R3 byte0 bit0");
        do_case(24'hFFF000 ^ 24'h00A0B0, 24'h00A0B0, "R3 byte511 bit7");
        do_case({12'h2A5, ~12'h2A5} ^ 24'h0F0F0F, 24'h0F0F0F, "R1 R3 mid byte");
        do_case(24'h000001 ^ 24'h777777, 24'h777777, "R5 code bit0");
        do_case(24'h800000 ^ 24'h777777, 24'h777777, "R5 code bit23");
        do_case(24'h000003 ^ 24'h555555, 24'h555555, "R6 two bits");

        // constrained random mix
        for (int i = 0; i < 80; i++) begin
            logic [23:0] s, d;
            logic [11:0] hi;
            int k;
            s = 24'($urandom);
            k = $urandom_range(0, 3);
            case (k)
                0: d = 24'd0;
                1: begin
                    hi = {9'($urandom_range(0, 511)), 3'($urandom_range(0, 7))};
                    d = {hi, ~hi};
                end
                2: d = 24'd1 << $urandom_range(0, 23);
                default: d = 24'($urandom);
            endcase
            do_case(s ^ d, s, (k == 1) ? "R3 random" : (k == 2) ? "R5 random" :
                              (k == 0) ? "R2 random" : "R6 random");
        end

        // R9: second start during a correction is ignored
        begin
            logic [23:0] s, c;
            int bi, ki, ev;
            s = 24'h13579B;
            c = s ^ {12'h155, ~12'h155};
            ev = ref_verdict(c, s, 512, bi, ki);
            @(negedge clk);
            {calc_b2, calc_b1, calc_b0} = c;
            {ref_b2, ref_b1, ref_b0} = s;
            start = 1'b1;
            @(negedge clk);
            {calc_b2, calc_b1, calc_b0} = s;
            n = 1;
            @(negedge clk);
            start = 1'b0;
            n = 2;
            while (!done && n < 20) begin
                @(negedge clk);
                n++;
            end
            check(int'(status) == ev, "R9 status", int'(status), ev);
            check(n == 4, "R9 latency", n, 4);
            model[bi] = model[bi] ^ (8'd1 << ki);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check(done == 1'b0, "R9 R10 no second done", int'(done), 0);
            end
            check(int'(status) == ev, "R10 status held", int'(status), ev);
            rd_byte(bi, rd);
            check(rd == model[bi], "R9 fixed byte", int'(rd), int'(model[bi]));
        end

        // R11: buffer write during a correction is dropped
        begin
            logic [23:0] s, c;
            int bi, ki, ev;
            s = 24'h2468AC;
            c = s ^ {12'h3F0, ~12'h3F0};
            ev = ref_verdict(c, s, 512, bi, ki);
            @(negedge clk);
            {calc_b2, calc_b1, calc_b0} = c;
            {ref_b2, ref_b1, ref_b0} = s;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            buf_we = 1'b1; buf_addr = 9'd7; buf_wdata = ~model[7];
            @(negedge clk);
            buf_we = 1'b0;
            n = 2;
            while (!done && n < 20) begin
                @(negedge clk);
                n++;
            end
            check(int'(status) == ev, "R11 status under write", int'(status), ev);
            model[bi] = model[bi] ^ (8'd1 << ki);
            rd_byte(7, rd);
            check(rd == model[7], "R11 busy write dropped", int'(rd), int'(model[7]));
            rd_byte(bi, rd);
            check(rd == model[bi], "R11 fix under write", int'(rd), int'(model[bi]));
        end

        // R4: 256-byte instance, byte index beyond the sector
        begin
            logic [11:0] hi;
            @(negedge clk);
            s_we = 1'b1; s_addr = 8'd44; s_wdata = 8'h5A;
            @(negedge clk);
            s_addr = 8'd100; s_wdata = 8'h33;
            @(negedge clk);
            s_we = 1'b0;
            hi = {9'd300, 3'd2};
            {s_c2, s_c1, s_c0} = {hi, ~hi};
            {s_r2, s_r1, s_r0} = 24'd0;
            s_start = 1'b1;
            @(negedge clk);
            s_start = 1'b0;
            n = 1;
            while (!s_done && n < 20) begin
                @(negedge clk);
                n++;
            end
            check(s_status == 2'd3, "R4 out of range", int'(s_status), 3);
            check(n == 2, "R4 latency", n, 2);
            s_addr = 8'd44;
            @(negedge clk);
            check(s_rdata == 8'h5A, "R4 no write", int'(s_rdata), 'h5A);
            hi = {9'd100, 3'd4};
            {s_c2, s_c1, s_c0} = {hi, ~hi};
            s_start = 1'b1;
            @(negedge clk);
            s_start = 1'b0;
            n = 1;
            while (!s_done && n < 20) begin
                @(negedge clk);
                n++;
            end
            check(s_status == 2'd1, "R4 in range fixed", int'(s_status), 1);
            s_addr = 8'd100;
            @(negedge clk);
            @(negedge clk);
            check(s_rdata == 8'h23, "R4 in range byte", int'(s_rdata), 'h23);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule